// File: doc/BRIEF.md
# Root Port Status-Change Unit

This block keeps the change flags and a few live status bits for one downstream port of a USB host controller's root hub. It times two port sequences itself. A port reset lasts a set number of millisecond ticks. A resume has three phases: a resume pulse counted in ticks, then a low-speed end-of-packet counted in clock cycles, then a resynchronization delay counted in ticks. When a sequence finishes, the block raises a sticky change flag. It also raises a sticky flag when the port's over-current input changes level.

Host software reads one 32-bit status word. It clears change flags by writing ones to them. The millisecond timers move only on a single-cycle `msTick` pulse, so a test can run them with a short tick period. Reset and resume commands arrive as single-cycle pulses. A reset command cuts short a resume that is running.

Top module: `port_status_change`

## Requirements
- R1: A `startReset` pulse makes bit 0 (reset busy) read 1. Bit 20 (reset-done change) becomes 1, and bit 0 returns to 0, at the clock edge that samples the RESET_MS-th `msTick` counted after the command cycle. A tick in the command cycle itself is not counted.
- R2: A `startResume` pulse while idle makes bit 1 (resume busy) read 1. The sequence then runs RESUME_MS ticks, then EOP_CYCLES clock cycles, then RESYNC_MS ticks. Bit 18 (resume-done change) becomes 1, and bit 1 returns to 0, at the edge that samples the last resync tick.
- R3: Bit 2 holds the registered over-current input. Bit 19 (over-current change) becomes 1 at any edge where `ovrCurIn` differs from bit 2. When `globalOcMode` is 1, bit 19 is never set.
- R4: Writing 1 to bit 18, 19 or 20 clears that flag. Writing 0 to it leaves it unchanged.
- R5: If a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R6: The edge that sets bit 20 also clears bit 18.
- R7: Bits 31 to 21, and every bit not named above, read 0. Writes to them have no effect.
- R8: After `rstN` is low, the status word reads 0.
- R9: A `startReset` pulse during a resume aborts it: bit 1 drops, and the reset counts RESET_MS ticks from zero. A `startResume` pulse during a reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| msTick | input | 1 | One-cycle pulse per millisecond |
| ovrCurIn | input | 1 | Port over-current level |
| globalOcMode | input | 1 | 1 when over-current is reported globally rather than per port |
| startReset | input | 1 | One-cycle port reset command |
| startResume | input | 1 | One-cycle resume command |
| regWrEn | input | 1 | Status word write strobe |
| regWrData | input | 32 | Write data (ones clear change flags) |
| regRdData | output | 32 | Status word |

## Verification
Two cases are hard to produce from the ports. The first is a reset that ends in the same cycle as a software clear of its own flag. The bench reaches it by counting ticks exactly and raising the write strobe on the cycle of the final tick. The second is a reset command that arrives part-way through the resume pulse, followed by a check that the full reset tick count starts over. A behavioural model follows every cycle, including the clock-counted end-of-packet phase, so any drift in phase boundaries shows up.

// File: rtl/port_stat_pkg.sv
package port_stat_pkg;
  typedef enum logic [2:0] {
    PS_IDLE, PS_RESET, PS_RESUME, PS_EOP, PS_RESYNC
  } portSeq_e;

  typedef struct packed {
    logic resetDone;
    logic resumeDone;
  } seqStrobe_t;

  localparam int RST_CHG_BIT  = 20;
  localparam int OC_CHG_BIT   = 19;
  localparam int RSM_CHG_BIT  = 18;
  localparam int OC_STATE_BIT = 2;
  localparam int RSM_BUSY_BIT = 1;
  localparam int RST_BUSY_BIT = 0;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/port_seq_ctrl.sv
module port_seq_ctrl
  import port_stat_pkg::*;
#(
  parameter int RESET_MS   = 10,
  parameter int RESUME_MS  = 20,
  parameter int RESYNC_MS  = 3,
  parameter int EOP_CYCLES = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       startReset,
  input  logic       startResume,
  output seqStrobe_t strobes,
  output logic       resetBusy,
  output logic       resumeBusy
);
  localparam int CNT_MAX = maxOf(maxOf(RESET_MS, RESUME_MS), maxOf(RESYNC_MS, EOP_CYCLES));
  localparam int CW = $clog2(CNT_MAX + 1);

  portSeq_e st, stNext;
  logic [CW-1:0] cnt, cntNext;

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    strobes = '0;
    if (startReset) begin
      stNext  = PS_RESET;
      cntNext = '0;
    end else begin
      case (st)
        PS_IDLE: if (startResume) begin
          stNext  = PS_RESUME;
          cntNext = '0;
        end
        PS_RESET: if (msTick) begin
          if (cnt == CW'(RESET_MS - 1)) begin
            stNext = PS_IDLE;
            cntNext = '0;
            strobes.resetDone = 1'b1;
          end else cntNext = cnt + 1'b1;
        end
        PS_RESUME: if (msTick) begin
          if (cnt == CW'(RESUME_MS - 1)) begin
            stNext = PS_EOP;
            cntNext = '0;
          end else cntNext = cnt + 1'b1;
        end
        PS_EOP: begin
          if (cnt == CW'(EOP_CYCLES - 1)) begin
            stNext = PS_RESYNC;
            cntNext = '0;
          end else cntNext = cnt + 1'b1;
        end
        PS_RESYNC: if (msTick) begin
          if (cnt == CW'(RESYNC_MS - 1)) begin
            stNext = PS_IDLE;
            cntNext = '0;
            strobes.resumeDone = 1'b1;
          end else cntNext = cnt + 1'b1;
        end
        default: begin
          stNext  = PS_IDLE;
          cntNext = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= PS_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end

  assign resetBusy  = (st == PS_RESET);
  assign resumeBusy = (st == PS_RESUME) || (st == PS_EOP) || (st == PS_RESYNC);

  // R1: a reset can only finish on a tick while the reset phase is active
  p_reset_done_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resetDone |-> (msTick && resetBusy));
  // R2: a resume can only finish on a tick while the resume is active
  p_resume_done_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resumeDone |-> (msTick && resumeBusy));
  // R9: a reset command always leaves the block in the reset phase
  p_reset_aborts_r9: assert property (@(posedge clk) disable iff (!rstN)
    startReset |=> (resetBusy && !resumeBusy));
endmodule

// File: rtl/port_flag_dp.sv
module port_flag_dp
  import port_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  strobes,
  input  logic        resetBusy,
  input  logic        resumeBusy,
  input  logic        ovrCurIn,
  input  logic        globalOcMode,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);
  logic rstChg, ocChg, rsmChg, ocState;
  logic wrRst, wrOc, wrRsm, ocEvent;
  logic unusedWrBits;

  assign wrRst   = regWrEn && regWrData[RST_CHG_BIT];
  assign wrOc    = regWrEn && regWrData[OC_CHG_BIT];
  assign wrRsm   = regWrEn && regWrData[RSM_CHG_BIT];
  assign ocEvent = (ovrCurIn != ocState) && !globalOcMode;
  assign unusedWrBits = ^{regWrData[31:21], regWrData[17:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstChg  <= 1'b0;
      ocChg   <= 1'b0;
      rsmChg  <= 1'b0;
      ocState <= 1'b0;
    end else begin
      ocState <= ovrCurIn;
      if (strobes.resetDone) rstChg <= 1'b1;
      else if (wrRst)        rstChg <= 1'b0;
      if (ocEvent)           ocChg  <= 1'b1;
      else if (wrOc)         ocChg  <= 1'b0;
      if (strobes.resetDone)       rsmChg <= 1'b0;
      else if (strobes.resumeDone) rsmChg <= 1'b1;
      else if (wrRsm)              rsmChg <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[RST_CHG_BIT]  = rstChg;
    regRdData[OC_CHG_BIT]   = ocChg;
    regRdData[RSM_CHG_BIT]  = rsmChg;
    regRdData[OC_STATE_BIT] = ocState;
    regRdData[RSM_BUSY_BIT] = resumeBusy;
    regRdData[RST_BUSY_BIT] = resetBusy;
  end

  // R5: a reset completion sets its flag even under a same-cycle clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resetDone |=> rstChg);
  // R6: reset completion wipes the resume-done flag
  p_reset_clears_resume_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resetDone |=> !rsmChg);
  // R4: a write-1 with no competing event clears the over-current flag
  p_w1c_oc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrOc && !ocEvent) |=> !ocChg);
  // R4: without a write-1 the flag is held
  p_write0_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ocChg && !wrOc) |=> ocChg);
  // R3: global over-current mode never raises the per-port flag
  p_global_oc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (globalOcMode && !ocChg) |=> !ocChg);
endmodule

// File: rtl/port_status_change.sv
module port_status_change
  import port_stat_pkg::*;
#(
  parameter int RESET_MS   = 10,
  parameter int RESUME_MS  = 20,
  parameter int RESYNC_MS  = 3,
  parameter int EOP_CYCLES = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        msTick,
  input  logic        ovrCurIn,
  input  logic        globalOcMode,
  input  logic        startReset,
  input  logic        startResume,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);
  seqStrobe_t strobes;
  logic resetBusy, resumeBusy;

  port_seq_ctrl #(
    .RESET_MS(RESET_MS), .RESUME_MS(RESUME_MS),
    .RESYNC_MS(RESYNC_MS), .EOP_CYCLES(EOP_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .msTick(msTick),
    .startReset(startReset), .startResume(startResume),
    .strobes(strobes), .resetBusy(resetBusy), .resumeBusy(resumeBusy)
  );

  port_flag_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .resetBusy(resetBusy), .resumeBusy(resumeBusy),
    .ovrCurIn(ovrCurIn), .globalOcMode(globalOcMode),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );
endmodule

// File: tb/port_status_change_bench.sv
`timescale 1ns/1ps
module port_status_change_bench;
  localparam int RST_T = 10, RSM_T = 20, SYNC_T = 3, EOP_C = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0, msTick = 1'b0, ovrCurIn = 1'b0, globalOcMode = 1'b0;
  logic startReset = 1'b0, startResume = 1'b0, regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  port_status_change u_port_status_change (
    .clk(clk), .rstN(rstN), .msTick(msTick), .ovrCurIn(ovrCurIn),
    .globalOcMode(globalOcMode), .startReset(startReset),
    .startResume(startResume), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  // behavioural reference: phase 0 idle, 1 reset, 2 pulse, 3 eop, 4 resync
  int mPhase = 0, mCnt = 0;
  bit mRc = 0, mOcc = 0, mSc = 0, mOc = 0;

  always @(posedge clk) begin
    bit rDone, sDone, ocEv;
    rDone = 0; sDone = 0;
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mRc = 0; mOcc = 0; mSc = 0; mOc = 0;
    end else begin
      if (startReset) begin
        mPhase = 1; mCnt = 0;
      end else if (mPhase == 0) begin
        if (startResume) begin mPhase = 2; mCnt = 0; end
      end else if (mPhase == 3) begin
        mCnt++;
        if (mCnt == EOP_C) begin mPhase = 4; mCnt = 0; end
      end else if (msTick) begin
        mCnt++;
        if (mPhase == 1 && mCnt == RST_T) begin rDone = 1; mPhase = 0; mCnt = 0; end
        else if (mPhase == 2 && mCnt == RSM_T) begin mPhase = 3; mCnt = 0; end
        else if (mPhase == 4 && mCnt == SYNC_T) begin sDone = 1; mPhase = 0; mCnt = 0; end
      end
      ocEv = (ovrCurIn != mOc) && !globalOcMode;
      mOc = ovrCurIn;
      if (regWrEn && regWrData[20]) mRc = 0;
      if (rDone) mRc = 1;
      if (regWrEn && regWrData[19]) mOcc = 0;
      if (ocEv) mOcc = 1;
      if (regWrEn && regWrData[18]) mSc = 0;
      if (sDone) mSc = 1;
      if (rDone) mSc = 0;
    end
  end

  always @(negedge clk) begin
    logic [31:0] exp;
    exp = '0;
    exp[20] = mRc; exp[19] = mOcc; exp[18] = mSc; exp[2] = mOc;
    exp[1] = (mPhase >= 2); exp[0] = (mPhase == 1);
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s model compare: actual %h expected %h",
        (regRdData[20] !== exp[20]) ? "R1" : (regRdData[18] !== exp[18]) ? "R2" :
        (regRdData[19] !== exp[19]) ? "R3" : "R7", regRdData, exp);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1; cyc(); msTick = 1'b0; cyc(); cyc();
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    regWrEn = 1'b1; regWrData = d; cyc(); regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulseReset();
    startReset = 1'b1; cyc(); startReset = 1'b0;
  endtask

  task automatic pulseResume();
    startResume = 1'b1; cyc(); startResume = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1; cyc();
    checks++;
    if (regRdData !== 32'h0) begin errors++; $display("FAIL R8: actual %h expected 0", regRdData); end

    // R7: writes to reserved and unnamed bits leave the word at zero
    wr(32'hFFFF_FFFF);
    checks++;
    if (regRdData !== 32'h0) begin errors++; $display("FAIL R7: actual %h expected 0", regRdData); end

    // R1: reset timing
    pulseReset();
    chk(regRdData[0], 1'b1, "R1 busy");
    ticks(RST_T - 1);
    chk(regRdData[20], 1'b0, "R1 early");
    ticks(1);
    chk(regRdData[20], 1'b1, "R1 done");
    chk(regRdData[0], 1'b0, "R1 idle");

    // R4: write 0 keeps, write 1 clears
    wr(32'h0);
    chk(regRdData[20], 1'b1, "R4 write0");
    wr(32'h0010_0000);
    chk(regRdData[20], 1'b0, "R4 write1");

    // R3: over-current change per port, suppressed globally
    ovrCurIn = 1'b1; cyc();
    chk(regRdData[19], 1'b1, "R3 rise");
    chk(regRdData[2], 1'b1, "R3 state");
    wr(32'h0008_0000);
    chk(regRdData[19], 1'b0, "R4 oc clear");
    globalOcMode = 1'b1;
    ovrCurIn = 1'b0; cyc(); ovrCurIn = 1'b1; cyc();
    chk(regRdData[19], 1'b0, "R3 global");
    globalOcMode = 1'b0; ovrCurIn = 1'b0; cyc();
    wr(32'h0008_0000);

    // R2: full resume sequence
    pulseResume();
    chk(regRdData[1], 1'b1, "R2 busy");
    ticks(RSM_T);
    repeat (EOP_C + 5) cyc();
    ticks(SYNC_T - 1);
    chk(regRdData[18], 1'b0, "R2 early");
    ticks(1);
    chk(regRdData[18], 1'b1, "R2 done");
    chk(regRdData[1], 1'b0, "R2 idle");

    // R6: reset completion clears the resume-done flag
    pulseReset();
    ticks(RST_T);
    chk(regRdData[18], 1'b0, "R6 cleared");
    chk(regRdData[20], 1'b1, "R6 set");
    wr(32'h0010_0000);

    // R5: set beats a same-cycle clear
    pulseReset();
    ticks(RST_T - 1);
    msTick = 1'b1; regWrEn = 1'b1; regWrData = 32'h0010_0000; cyc();
    msTick = 1'b0; regWrEn = 1'b0; regWrData = '0;
    chk(regRdData[20], 1'b1, "R5 set wins");
    wr(32'h0010_0000);

    // R9: reset aborts resume and restarts its count; resume ignored during reset
    pulseResume();
    ticks(5);
    pulseReset();
    chk(regRdData[1], 1'b0, "R9 abort");
    chk(regRdData[0], 1'b1, "R9 reset busy");
    pulseResume();
    chk(regRdData[1], 1'b0, "R9 resume ignored");
    ticks(RST_T - 1);
    chk(regRdData[20], 1'b0, "R9 full count");
    ticks(1);
    chk(regRdData[20], 1'b1, "R9 done");

    // R8: reset clears everything
    ovrCurIn = 1'b1; cyc();
    rstN = 1'b0; ovrCurIn = 1'b0; cyc(); rstN = 1'b1;
    checks++;
    if (regRdData !== 32'h0) begin errors++; $display("FAIL R8 re-reset: actual %h expected 0", regRdData); end
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule